// File: doc/BRIEF.md
# Bit-Band Alias Bridge

The bridge sits between a 32-bit requester and a word-addressed memory. It lets software read or change a single bit of a memory word with one ordinary word access. Two regions are covered, an SRAM region (top address nibble 0x2) and a peripheral region (top address nibble 0x4). In each region, the first 1 MB is the base window. A 32 MB alias window starts 0x02000000 above the region start. Every word of the alias window stands for one bit of one base-window word.

An alias read turns into one memory read of the target word and returns the chosen bit in bit 0 of the response. An alias write turns into a read of the target word followed by a write-back of that word with only the chosen bit changed. During both memory transactions the bridge raises a lock toward the memory arbiter, so no other master can modify the word between the read and the write-back. Any other address passes straight through in a single transaction.

Both sides use a valid/ready handshake. A transaction completes in the cycle where valid and ready are both high, and read data is valid in that same cycle.

Top module: `bb_alias_bridge`

## Requirements
- R1: An address is an alias address when bits [31:28] are 0x2 or 0x4 and bits [27:25] equal 3'b001. The target word address is {addr[31:28], 8'h00, addr[24:7], 2'b00}. The selected bit number is addr[6:2]. An alias word access to 0x22000000 therefore targets bit 0 of the word at 0x20000000.
- R2: An alias read performs exactly one memory read at the target word address with the lock low. It returns 0x00000001 if the selected bit is set and 0x00000000 otherwise.
- R3: An alias write uses only bit 0 of the write data: 1 sets the selected bit and 0 clears it. The other 31 bits of the target word keep their values.
- R4: An alias write performs exactly two memory transactions: a read of the target word, then a write of the merged word to the same address. Upstream ready stays low until the cycle in which the write-back is accepted, and it is high in that cycle.
- R5: The lock is high during both memory transactions of an alias write. The lock is low during pass-through accesses, during alias reads, and when no request is present.
- R6: A non-alias access becomes exactly one memory transaction with the lock low. The address, the direction and the write data are unchanged, and read data is returned unchanged.
- R7: Starting from a cleared word, setting bits 0, 1 and 31 through the alias window, reading bit 0 through the alias window, and then setting bit 30 leaves 0xC0000003 in the base word.
- R8: With reset asserted or no request present, memory valid, lock and upstream ready are low. An asserted reset abandons a read-modify-write that is waiting for its write-back, and the target word is left unchanged.
- R9: The window edges decode correctly. Alias address 0x23FFFFFC reaches bit 31 of base word 0x200FFFFC. Addresses next to the alias window (0x21FFFFFC, 0x24000000) and addresses in other regions (0x62000000) pass through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Requester has an access pending |
| req_ready | output | 1 | Access accepted and completed this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the word access |
| req_wdata | input | 32 | Write data |
| req_rdata | output | 32 | Read data, valid when req_valid and req_ready are high on a read |
| mem_valid | output | 1 | Memory transaction pending |
| mem_ready | input | 1 | Memory accepts and completes the transaction this cycle |
| mem_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_lock | output | 1 | Arbiter lock held for the read-modify-write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready on a read |

## Verification
The assertions assume that the requester follows the handshake. Once it raises req_valid, it keeps the request stable and does not drop it until req_ready is seen, except when reset is asserted at the same time. The lock and read-modify-write properties depend on this, because the write-back phase does not sample the request again. The bench drives every access through one task that holds the request until completion. The only request it withdraws early is the one abandoned in the mid-sequence reset test, and there it lowers reset in the same step. The memory model inserts wait states so that both memory phases and the upstream stall are exercised.

// File: rtl/bb_pkg.sv
package bb_pkg;

  // Width of the region tag at the top of the address.
  localparam int TAG_W = 4;

  // Read-modify-write sequencer phases.
  typedef enum logic {
    RMW_IDLE = 1'b0,  // no write-back owed; the read phase is driven from here
    RMW_WB   = 1'b1   // merged word held; write-back in flight
  } rmw_state_e;

endpackage

// File: rtl/bb_rst_sync.sv
module bb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  // Assert asynchronously, release on a clock edge after STAGES cycles.
  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bb_window_decode.sv
module bb_window_decode #(
  parameter int ADDR_W         = 32,
  parameter int DATA_W         = 32,
  parameter int NUM_REGIONS    = 2,
  parameter int BASE_SPAN_LOG2 = 20,
  parameter logic [NUM_REGIONS*bb_pkg::TAG_W-1:0] REGION_TAGS = 8'h42,
  localparam int TAG_W      = bb_pkg::TAG_W,
  localparam int BYTE_OFF   = $clog2(DATA_W / 8),
  localparam int BIT_W      = $clog2(DATA_W),
  localparam int ALIAS_LOG2 = BASE_SPAN_LOG2 + BIT_W,
  localparam int SEL_W      = ADDR_W - TAG_W - ALIAS_LOG2,
  localparam int PAD_W      = ADDR_W - TAG_W - BASE_SPAN_LOG2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_alias,
  output logic [ADDR_W-1:0] word_addr,
  output logic [BIT_W-1:0]  bit_sel
);

  logic [NUM_REGIONS-1:0] region_hit;
  logic [TAG_W-1:0]       addr_tag;
  logic                   sel_ok;

  assign addr_tag = addr[ADDR_W-1 -: TAG_W];
  // The alias window starts exactly one alias span above the region start.
  assign sel_ok   = (addr[ALIAS_LOG2 +: SEL_W] == SEL_W'(1));

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    assign region_hit[g] = sel_ok && (addr_tag == REGION_TAGS[g*TAG_W +: TAG_W]);
  end

  assign in_alias  = |region_hit;
  assign bit_sel   = addr[BYTE_OFF +: BIT_W];
  assign word_addr = {addr_tag,
                      {PAD_W{1'b0}},
                      addr[ALIAS_LOG2-1 : BIT_W+BYTE_OFF],
                      {BYTE_OFF{1'b0}}};

endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge #(
  parameter int DATA_W = 32,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] word_in,
  input  logic [BIT_W-1:0]  bit_sel,
  input  logic              bit_val,
  output logic [DATA_W-1:0] word_out,
  output logic              bit_pick
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign word_out[i] = (bit_sel == BIT_W'(i)) ? bit_val : word_in[i];
  end

  assign bit_pick = word_in[bit_sel];

endmodule

// File: rtl/bb_rmw_ctrl.sv
module bb_rmw_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,      // alias write present at the port
  input  logic              mem_ready,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [DATA_W-1:0] merged,
  output logic              in_wb,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  output logic              done
);

  import bb_pkg::*;

  rmw_state_e        state_q, state_d;
  logic              load_en;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  // The read phase completes when memory accepts it in the idle state.
  assign load_en = (state_q == RMW_IDLE) && start && mem_ready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      RMW_IDLE: if (load_en)   state_d = RMW_WB;
      RMW_WB:   if (mem_ready) state_d = RMW_IDLE;
      default:                 state_d = RMW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RMW_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Data path registers: loaded once per sequence, no reset needed.
  always_ff @(posedge clk) begin
    if (load_en) begin
      addr_q <= tgt_addr;
      data_q <= merged;
    end
  end

  assign in_wb   = (state_q == RMW_WB);
  assign wb_addr = addr_q;
  assign wb_data = data_q;
  assign done    = in_wb && mem_ready;

endmodule

// File: rtl/bb_alias_bridge.sv
module bb_alias_bridge #(
  parameter int ADDR_W         = 32,
  parameter int DATA_W         = 32,
  parameter int NUM_REGIONS    = 2,
  parameter int BASE_SPAN_LOG2 = 20,
  parameter logic [NUM_REGIONS*bb_pkg::TAG_W-1:0] REGION_TAGS = 8'h42,
  parameter int RST_STAGES     = 2,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] req_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic              mem_lock,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic              rst_int_n;
  logic              in_alias;
  logic [ADDR_W-1:0] tgt_addr;
  logic [BIT_W-1:0]  bit_sel;
  logic [DATA_W-1:0] merged;
  logic              bit_pick;
  logic              alias_wr;
  logic              alias_rd;
  logic              in_wb;
  logic              rmw_done;
  logic [ADDR_W-1:0] wb_addr;
  logic [DATA_W-1:0] wb_data;

  bb_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_int_n)
  );

  bb_window_decode #(
    .ADDR_W         (ADDR_W),
    .DATA_W         (DATA_W),
    .NUM_REGIONS    (NUM_REGIONS),
    .BASE_SPAN_LOG2 (BASE_SPAN_LOG2),
    .REGION_TAGS    (REGION_TAGS)
  ) u_dec (
    .addr      (req_addr),
    .in_alias  (in_alias),
    .word_addr (tgt_addr),
    .bit_sel   (bit_sel)
  );

  bb_bit_merge #(.DATA_W(DATA_W)) u_merge (
    .word_in  (mem_rdata),
    .bit_sel  (bit_sel),
    .bit_val  (req_wdata[0]),
    .word_out (merged),
    .bit_pick (bit_pick)
  );

  assign alias_wr = req_valid && req_write && in_alias;
  assign alias_rd = req_valid && !req_write && in_alias;

  bb_rmw_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rmw (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (alias_wr),
    .mem_ready (mem_ready),
    .tgt_addr  (tgt_addr),
    .merged    (merged),
    .in_wb     (in_wb),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data),
    .done      (rmw_done)
  );

  // Path select: write-back, read phase of an alias write, alias read, pass-through.
  always_comb begin
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_addr  = req_addr;
    mem_wdata = req_wdata;
    req_ready = 1'b0;
    req_rdata = '0;
    if (!rst_int_n) begin
      mem_valid = 1'b0;
    end else if (in_wb) begin
      mem_valid = 1'b1;
      mem_write = 1'b1;
      mem_addr  = wb_addr;
      mem_wdata = wb_data;
      req_ready = rmw_done;
    end else if (alias_wr) begin
      mem_valid = 1'b1;
      mem_addr  = tgt_addr;
      mem_wdata = '0;
    end else if (alias_rd) begin
      mem_valid = 1'b1;
      mem_addr  = tgt_addr;
      mem_wdata = '0;
      req_ready = mem_ready;
      req_rdata = {{(DATA_W-1){1'b0}}, bit_pick};
    end else begin
      mem_valid = req_valid;
      mem_write = req_write;
      req_ready = req_valid && mem_ready;
      req_rdata = mem_rdata;
    end
  end

  assign mem_lock = rst_int_n && (in_wb || alias_wr);

endmodule

// File: rtl/bb_alias_bridge_chk.sv
module bb_alias_bridge_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic [DATA_W-1:0] req_rdata,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic              mem_lock,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mem_rdata
);

  AST_LOCK_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock |-> (req_valid && req_write)); // R5

  AST_WB_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_lock && !mem_write) |=> (mem_valid && mem_write && mem_lock)); // R4

  AST_WB_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_lock && !mem_write) |=> (mem_addr == $past(mem_addr))); // R4

  AST_NO_EARLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lock && !mem_write) |-> !req_ready); // R4

  AST_SINGLE_BIT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_lock && !mem_write) |=> ($countones(mem_wdata ^ $past(mem_rdata)) <= 1)); // R3

  AST_ALIAS_READ_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && (mem_addr != req_addr)) |-> (req_rdata[DATA_W-1:1] == '0)); // R2

  AST_PASS_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_lock && (mem_addr == req_addr)) |-> ((mem_write == req_write) && (!req_write || (mem_wdata == req_wdata)))); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!mem_valid && !mem_lock && !req_ready)); // R8

endmodule

bind bb_alias_bridge bb_alias_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .req_rdata (req_rdata),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_write (mem_write),
  .mem_lock  (mem_lock),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata)
);

// File: tb/tb_bb_alias_bridge.sv
module tb_bb_alias_bridge;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [31:0] req_addr;
  logic [31:0] req_wdata;
  logic [31:0] req_rdata;
  logic        mem_valid;
  logic        mem_ready;
  logic        mem_write;
  logic        mem_lock;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;

  int n_chk;
  int n_fail;

  bb_alias_bridge dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_rdata (req_rdata),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_write (mem_write),
    .mem_lock  (mem_lock),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  // 50 MHz clock
  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------------- memory model: 16 tagged words ----------------
  logic        stall_en;
  logic        hold_off;
  int          stall_cnt;
  logic [31:0] tag_q [16];
  logic [31:0] dat_q [16];
  logic        vld_q [16];
  int          log_n;
  logic [31:0] log_addr [64];
  logic        log_wr   [64];
  logic        log_lk   [64];
  logic [31:0] log_dat  [64];

  always @(negedge clk) begin
    stall_cnt <= stall_cnt + 1;
    mem_ready <= hold_off ? 1'b0 : (!stall_en || (stall_cnt % 3 == 0));
  end

  always_comb begin
    mem_rdata = 32'h0;
    for (int i = 0; i < 16; i++)
      if (vld_q[i] && tag_q[i] == mem_addr) mem_rdata = dat_q[i];
  end

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      log_addr[log_n % 64] = mem_addr;
      log_wr[log_n % 64]   = mem_write;
      log_lk[log_n % 64]   = mem_lock;
      log_dat[log_n % 64]  = mem_wdata;
      log_n = log_n + 1;
      if (mem_write) begin
        automatic int slot = -1;
        for (int i = 0; i < 16; i++)
          if (slot < 0 && vld_q[i] && tag_q[i] == mem_addr) slot = i;
        for (int i = 0; i < 16; i++)
          if (slot < 0 && !vld_q[i]) slot = i;
        if (slot >= 0) begin
          vld_q[slot] = 1'b1;
          tag_q[slot] = mem_addr;
          dat_q[slot] = mem_wdata;
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Alias decode per R1
  function automatic logic is_alias(input logic [31:0] a);
    return ((a[31:28] == 4'h2) || (a[31:28] == 4'h4)) && (a[27:25] == 3'b001);
  endfunction

  function automatic logic [31:0] xlate(input logic [31:0] a);
    return {a[31:28], 8'h00, a[24:7], 2'b00};
  endfunction

  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int ntx, output int base);
    automatic int waited = 0;
    automatic logic got = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = wd;
    base      = log_n;
    rd        = 32'h0;
    while (!got && waited < 60) begin
      #1;
      if (req_ready) begin
        got = 1'b1;
        rd  = req_rdata;
        if (wr && is_alias(a)) begin
          // R4: ready only while the write-back is being accepted
          chk("R4 ready during write-back", {31'h0, mem_write}, 32'h1);
          chk("R4 read phase done before ready", log_n - base, 1);
          chk("R5 lock at completion", {31'h0, mem_lock}, 32'h1);
        end
        @(posedge clk);
      end else begin
        waited++;
        @(negedge clk);
      end
    end
    if (!got) chk("R4 request never completed", 32'h0, 32'h1);
    @(negedge clk);
    req_valid = 1'b0;
    ntx = log_n - base;
  endtask

  // ---------------- vector table ----------------
  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] expv;
  } vec_t;

  localparam int NVEC = 28;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 32'h20000000, 32'h00000000, 32'h0},         // clear word (R7)
    '{1'b1, 32'h22000000, 32'h00000001, 32'h0},         // bit0 (R7, R1)
    '{1'b1, 32'h22000004, 32'h00000001, 32'h0},         // bit1
    '{1'b1, 32'h2200007C, 32'h00000001, 32'h0},         // bit31
    '{1'b0, 32'h22000000, 32'h00000000, 32'h00000001},  // read bit0 (R2)
    '{1'b1, 32'h22000078, 32'h00000001, 32'h0},         // bit30
    '{1'b0, 32'h20000000, 32'h00000000, 32'hC0000003},  // R7 result
    '{1'b1, 32'h40000010, 32'hA5A5A5A5, 32'h0},         // peripheral base (R6)
    '{1'b1, 32'h42000200, 32'hFFFFFFFE, 32'h0},         // clear bit0, upper data ignored (R3)
    '{1'b1, 32'h42000214, 32'hFFFFFFFE, 32'h0},         // clear bit5 (R3)
    '{1'b1, 32'h42000278, 32'h00000001, 32'h0},         // set bit30
    '{1'b0, 32'h40000010, 32'h00000000, 32'hE5A5A584},  // R3 merged word
    '{1'b0, 32'h42000214, 32'h00000000, 32'h00000000},  // R2 cleared bit
    '{1'b0, 32'h4200027C, 32'h00000000, 32'h00000001},  // R2 set bit31
    '{1'b1, 32'h200FFFFC, 32'h00000000, 32'h0},         // last base word (R9)
    '{1'b1, 32'h23FFFFFC, 32'h00000003, 32'h0},         // last alias word -> bit31
    '{1'b0, 32'h200FFFFC, 32'h00000000, 32'h80000000},  // R9
    '{1'b0, 32'h23FFFFFC, 32'h00000000, 32'h00000001},  // R9
    '{1'b1, 32'h21FFFFFC, 32'h12345678, 32'h0},         // below alias window (R9)
    '{1'b0, 32'h21FFFFFC, 32'h00000000, 32'h12345678},
    '{1'b1, 32'h62000000, 32'hCAFEF00D, 32'h0},         // other region (R9)
    '{1'b0, 32'h62000000, 32'h00000000, 32'hCAFEF00D},
    '{1'b1, 32'h24000000, 32'h0BADBEEF, 32'h0},         // above alias window (R9)
    '{1'b0, 32'h24000000, 32'h00000000, 32'h0BADBEEF},
    '{1'b1, 32'h20001234, 32'h00000000, 32'h0},         // mid-window word
    '{1'b1, 32'h220246B4, 32'h00000001, 32'h0},         // bit13 (R1)
    '{1'b0, 32'h20001234, 32'h00000000, 32'h00002000},  // R1 mapping
    '{1'b0, 32'h220246B0, 32'h00000000, 32'h00000000}   // bit12 clear (R2)
  };

  task automatic check_profile(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                               input int ntx, input int base);
    automatic int b0 = base % 64;
    automatic int b1 = (base + 1) % 64;
    if (is_alias(a) && wr) begin
      chk("R4 two memory transactions", ntx, 2);
      chk("R1 read phase address", log_addr[b0], xlate(a));
      chk("R4 first phase is read", {31'h0, log_wr[b0]}, 32'h0);
      chk("R5 lock on read phase", {31'h0, log_lk[b0]}, 32'h1);
      chk("R4 write-back address", log_addr[b1], xlate(a));
      chk("R4 second phase is write", {31'h0, log_wr[b1]}, 32'h1);
      chk("R5 lock on write-back", {31'h0, log_lk[b1]}, 32'h1);
    end else if (is_alias(a)) begin
      chk("R2 one memory read", ntx, 1);
      chk("R1 alias read address", log_addr[b0], xlate(a));
      chk("R2 memory read direction", {31'h0, log_wr[b0]}, 32'h0);
      chk("R5 no lock on alias read", {31'h0, log_lk[b0]}, 32'h0);
    end else begin
      chk("R6 one memory transaction", ntx, 1);
      chk("R6 address unchanged", log_addr[b0], a);
      chk("R6 direction unchanged", {31'h0, log_wr[b0]}, {31'h0, wr});
      chk("R5 no lock on pass-through", {31'h0, log_lk[b0]}, 32'h0);
      if (wr) chk("R6 write data unchanged", log_dat[b0], wd);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] rd;
    int ntx;
    int base;
    n_chk     = 0;
    n_fail    = 0;
    log_n     = 0;
    stall_cnt = 0;
    stall_en  = 1'b0;
    hold_off  = 1'b0;
    for (int i = 0; i < 16; i++) begin
      vld_q[i] = 1'b0;
      tag_q[i] = 32'h0;
      dat_q[i] = 32'h0;
    end
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = 32'h0;
    req_wdata = 32'h0;

    // R8: quiet in reset
    repeat (3) @(negedge clk);
    #1;
    chk("R8 mem_valid in reset", {31'h0, mem_valid}, 32'h0);
    chk("R8 lock in reset", {31'h0, mem_lock}, 32'h0);
    chk("R8 ready in reset", {31'h0, req_ready}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R8 idle mem_valid", {31'h0, mem_valid}, 32'h0);
    chk("R8 idle lock", {31'h0, mem_lock}, 32'h0);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      access(VEC[v].wr, VEC[v].addr, VEC[v].wdata, rd, ntx, base);
      if (!VEC[v].wr) chk($sformatf("R2/R6/R7 read data vector %0d", v), rd, VEC[v].expv);
      check_profile(VEC[v].wr, VEC[v].addr, VEC[v].wdata, ntx, base);
    end

    // R4: alias write under memory wait states (set bit2 of 0x20000000)
    stall_en = 1'b1;
    access(1'b1, 32'h22000008, 32'h00000001, rd, ntx, base);
    check_profile(1'b1, 32'h22000008, 32'h00000001, ntx, base);
    #1;
    chk("R5 lock released after sequence", {31'h0, mem_lock}, 32'h0);
    access(1'b0, 32'h20000000, 32'h0, rd, ntx, base);
    chk("R6 stalled pass-through read", rd, 32'hC0000007);
    access(1'b0, 32'h22000008, 32'h0, rd, ntx, base);
    chk("R2 stalled alias read", rd, 32'h00000001);
    stall_en = 1'b0;

    // R8: reset while the write-back is stalled (bit4 of 0x20000000)
    @(negedge clk);
    req_valid = 1'b1;
    req_write = 1'b1;
    req_addr  = 32'h22000010;
    req_wdata = 32'h00000001;
    #1;
    hold_off = 1'b1;
    @(negedge clk);
    #1;
    chk("R5 lock held in stalled write-back", {31'h0, mem_lock}, 32'h1);
    chk("R4 no ready while write-back stalled", {31'h0, req_ready}, 32'h0);
    rst_n     = 1'b0;
    req_valid = 1'b0;
    #1;
    chk("R8 reset drops mem_valid", {31'h0, mem_valid}, 32'h0);
    chk("R8 reset drops lock", {31'h0, mem_lock}, 32'h0);
    hold_off = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    access(1'b0, 32'h20000000, 32'h0, rd, ntx, base);
    chk("R8 abandoned write leaves word", rd, 32'hC0000007);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule